// File: doc/BRIEF.md
# Serial Controller Flag and Mode Register Unit

This unit keeps the operating state of a serial controller: a run/configuration enable, a master-select bit and six sticky error flags. Software never writes these flags as a value. It writes a strobe word in which each flag owns one set bit and one clear bit. A bit written as zero leaves its flag alone, so no read-modify-write is ever needed. Error events from the serial engine (transmit overflow, receive overflow, abort, transmit underflow and receive underflow) also set their flags. Each event source passes through its own enable bit.

The unit gates four interrupt requests through a 4-bit interrupt-enable register. The error request is the OR of all error flags, and it is raised only while its enable bit is set. The enable flag drives a mode output: low means configuration, high means run. Run mode cannot be left while the engine reports busy. The bus is a plain write strobe with an address and a combinational read-back.

Top module: `flagreg_ctrl`

## Requirements
- R1: After reset every flag, the error-enable register, the interrupt-enable register, run_mode, master_sel and all interrupt outputs are 0.
- R2: In a write to address 0 (strobe word), bit1 sets and bit0 clears the enable flag (run_mode), and bit3 sets and bit2 clears the master-select flag (master_sel). Each takes effect on the next clock edge.
- R3: In the strobe word, the error flags use these set/clear bit pairs: TE 12/8, RE 13/9, AE 14/10, TUE 15/11, RUE 5/4, ME 7/6. Strobe bits written as zero leave their flags unchanged.
- R4: A strobe word of 0x0F50 clears all six error flags in one write.
- R5: If a flag's set bit and clear bit are both 1 in the same write, the flag keeps its old value.
- R6: A clear of the enable flag is ignored while eng_busy is high. A set is accepted at any time.
- R7: Address 1 holds the error-enable register: bit0 gates evt_tx_ovf into TE, bit1 gates evt_rx_ovf into RE, bit2 gates evt_abort into AE, bit3 gates evt_tx_unf into TUE, and bit4 gates evt_rx_unf into RUE. A gated event sets its flag on the next edge. The event wins over a clear strobe in the same cycle. An event whose enable bit is 0 has no effect.
- R8: A read of address 0 returns EN at bit0, MS at bit1, ME at bit7, TE at bit8, RE at bit9, AE at bit10, TUE at bit11, RUE at bit12 and eng_busy at bit13. All other bits are 0. Addresses 1 and 2 read back their registers, zero-extended.
- R9: Address 2 holds the interrupt-enable register. irq_rx = req_rx AND bit0, irq_tx = req_tx AND bit1, and irq_frame = req_frame AND bit3.
- R10: irq_err is the OR of the six error flags ANDed with interrupt-enable bit2.
- R11: A write to address 3 changes no state, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| eng_busy | input | 1 | Serial engine busy |
| evt_tx_ovf | input | 1 | Transmit overflow event |
| evt_rx_ovf | input | 1 | Receive overflow event |
| evt_abort | input | 1 | Abort event |
| evt_tx_unf | input | 1 | Transmit underflow event |
| evt_rx_unf | input | 1 | Receive underflow event |
| req_rx | input | 1 | Raw receive request |
| req_tx | input | 1 | Raw transmit request |
| req_frame | input | 1 | Raw frame-end request |
| run_mode | output | 1 | 1 = run mode, 0 = configuration mode |
| master_sel | output | 1 | Master-select flag |
| irq_rx | output | 1 | Gated receive interrupt |
| irq_tx | output | 1 | Gated transmit interrupt |
| irq_err | output | 1 | Gated error interrupt |
| irq_frame | output | 1 | Gated frame-end interrupt |

## Verification
Directed patterns come first. Single set strobes, single clear strobes, both-ones ties, the 0x0F50 bulk clear and address-3 writes separate the bit-pair wiring from the tie-hold rule. Event pulses are sent with their enable off, with their enable on, and alongside a clear strobe of the same flag. These show whether gating and event priority are right. A clear of the enable flag with eng_busy high and then low separates the busy lock from an ordinary clear. A long seeded random run then mixes arbitrary strobe words, events, busy and requests. After every cycle the status word, the interrupts and the mode outputs are compared with a bench model. This catches wrong bit positions that the directed cases leave untouched.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  localparam int NUM_ERR = 6;
  localparam int NUM_HW  = 5;
  localparam int NUM_IRQ = 4;

  // error flag order: 0 TE, 1 RE, 2 AE, 3 TUE, 4 RUE, 5 ME
  function automatic int set_pos(input int i);
    case (i)
      0: return 12;
      1: return 13;
      2: return 14;
      3: return 15;
      4: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int clr_pos(input int i);
    case (i)
      0: return 8;
      1: return 9;
      2: return 10;
      3: return 11;
      4: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int stat_pos(input int i);
    case (i)
      0: return 8;
      1: return 9;
      2: return 10;
      3: return 11;
      4: return 12;
      default: return 7;
    endcase
  endfunction

  // hardware event wins; a tie of set and clear keeps the flag
  function automatic logic flag_next(input logic cur, input logic s,
                                     input logic c, input logic hw);
    return hw | (s & ~c) | (cur & ~(c & ~s));
  endfunction
endpackage

// File: rtl/flagreg_flag.sv
module flagreg_flag
  import flagreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= flag_next(q_o, set_i, clr_i, hw_i);
  end

  // R7
  hw_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_i |=> q_o);
  // R5
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i && !hw_i) |=> $stable(q_o));
  // R3
  strobe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  // R3
  strobe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !hw_i) |=> !q_o);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !hw_i) |=> $stable(q_o));
endmodule

// File: rtl/flagreg_mode.sv
module flagreg_mode
  import flagreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic ms_set_i,
  input  logic ms_clr_i,
  input  logic busy_i,
  output logic run_o,
  output logic ms_o,
  output logic clr_blocked_o
);
  logic en_clr_eff;

  // a lone clear is dropped while busy; a tie still holds
  assign en_clr_eff    = en_clr_i & (~busy_i | en_set_i);
  assign clr_blocked_o = en_clr_i & busy_i & ~en_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o <= 1'b0;
      ms_o  <= 1'b0;
    end else begin
      run_o <= flag_next(run_o, en_set_i, en_clr_eff, 1'b0);
      ms_o  <= flag_next(ms_o, ms_set_i, ms_clr_i, 1'b0);
    end
  end

  // R6
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && busy_i) |=> run_o);
  // R6
  blocked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_blocked_o |=> $stable(run_o));
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_i && !en_clr_i) |=> run_o);
  // R2
  ms_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_clr_i && !ms_set_i) |=> !ms_o);
endmodule

// File: rtl/flagreg_irq.sv
module flagreg_irq
  import flagreg_pkg::*;
(
  input  logic [NUM_ERR-1:0] err_i,
  input  logic [NUM_IRQ-1:0] ie_i,
  input  logic               req_rx_i,
  input  logic               req_tx_i,
  input  logic               req_frame_i,
  output logic               irq_rx_o,
  output logic               irq_tx_o,
  output logic               irq_err_o,
  output logic               irq_frame_o
);
  localparam int IE_RX = 0;
  localparam int IE_TX = 1;
  localparam int IE_ER = 2;
  localparam int IE_FR = 3;

  assign irq_rx_o    = req_rx_i    & ie_i[IE_RX];
  assign irq_tx_o    = req_tx_i    & ie_i[IE_TX];
  assign irq_err_o   = (|err_i)    & ie_i[IE_ER];
  assign irq_frame_o = req_frame_i & ie_i[IE_FR];
endmodule

// File: rtl/flagreg_ctrl.sv
module flagreg_ctrl
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              evt_tx_ovf,
  input  logic              evt_rx_ovf,
  input  logic              evt_abort,
  input  logic              evt_tx_unf,
  input  logic              evt_rx_unf,
  input  logic              req_rx,
  input  logic              req_tx,
  input  logic              req_frame,
  output logic              run_mode,
  output logic              master_sel,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_err,
  output logic              irq_frame
);
  localparam logic [ADDR_W-1:0] ADR_STROBE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_ERREN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_IRQEN  = ADDR_W'(2);
  localparam int BIT_EN  = 0;
  localparam int BIT_MS  = 1;
  localparam int BIT_BSY = 13;

  logic               strobe_wr;
  logic [NUM_HW-1:0]  err_en_q;
  logic [NUM_IRQ-1:0] irq_en_q;
  logic [NUM_ERR-1:0] err_q;
  logic [NUM_ERR-1:0] hw_set;
  logic [NUM_HW-1:0]  evt_raw;
  logic               clr_blocked;

  assign strobe_wr = bus_wr && (bus_addr == ADR_STROBE);
  assign evt_raw   = {evt_rx_unf, evt_tx_unf, evt_abort, evt_rx_ovf, evt_tx_ovf};
  // the mode error flag has no hardware source
  assign hw_set    = {1'b0, evt_raw & err_en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_en_q <= '0;
      irq_en_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_ERREN) err_en_q <= bus_wdata[NUM_HW-1:0];
      if (bus_addr == ADR_IRQEN) irq_en_q <= bus_wdata[NUM_IRQ-1:0];
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    localparam int SP = set_pos(g);
    localparam int CP = clr_pos(g);
    flagreg_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (strobe_wr & bus_wdata[SP]),
      .clr_i (strobe_wr & bus_wdata[CP]),
      .hw_i  (hw_set[g]),
      .q_o   (err_q[g])
    );
  end

  flagreg_mode u_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_set_i      (strobe_wr & bus_wdata[1]),
    .en_clr_i      (strobe_wr & bus_wdata[0]),
    .ms_set_i      (strobe_wr & bus_wdata[3]),
    .ms_clr_i      (strobe_wr & bus_wdata[2]),
    .busy_i        (eng_busy),
    .run_o         (run_mode),
    .ms_o          (master_sel),
    .clr_blocked_o (clr_blocked)
  );

  flagreg_irq u_irq (
    .err_i       (err_q),
    .ie_i        (irq_en_q),
    .req_rx_i    (req_rx),
    .req_tx_i    (req_tx),
    .req_frame_i (req_frame),
    .irq_rx_o    (irq_rx),
    .irq_tx_o    (irq_tx),
    .irq_err_o   (irq_err),
    .irq_frame_o (irq_frame)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_STROBE: begin
        bus_rdata[BIT_EN]  = run_mode;
        bus_rdata[BIT_MS]  = master_sel;
        bus_rdata[BIT_BSY] = eng_busy;
        for (int i = 0; i < NUM_ERR; i++) bus_rdata[stat_pos(i)] = err_q[i];
      end
      ADR_ERREN: bus_rdata[NUM_HW-1:0]  = err_en_q;
      ADR_IRQEN: bus_rdata[NUM_IRQ-1:0] = irq_en_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R4
  bulk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_wr && bus_wdata[15:0] == 16'h0F50 && hw_set == '0) |=> (err_q == '0));
  // R11
  spare_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3)) |=> ($stable(err_en_q) && $stable(irq_en_q)));
  // R10
  err_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q[2] |-> !irq_err);
  // R7
  gated_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_en_q[0] && !strobe_wr && !bus_wdata[12] && !err_q[0]) |=> !err_q[0]);
  // R6
  blocked_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_blocked |=> run_mode == $past(run_mode));
endmodule

// File: tb/flagreg_ctrl_tb.sv
module flagreg_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        eng_busy = 1'b0;
  logic [4:0]  evt = '0;
  logic        req_rx = 1'b0, req_tx = 1'b0, req_frame = 1'b0;
  logic        run_mode, master_sel, irq_rx, irq_tx, irq_err, irq_frame;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state; error order TE RE AE TUE RUE ME
  logic       m_en, m_ms;
  logic [5:0] m_err;
  logic [4:0] m_een;
  logic [3:0] m_ie;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagreg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .evt_tx_ovf(evt[0]), .evt_rx_ovf(evt[1]), .evt_abort(evt[2]),
    .evt_tx_unf(evt[3]), .evt_rx_unf(evt[4]),
    .req_rx(req_rx), .req_tx(req_tx), .req_frame(req_frame),
    .run_mode(run_mode), .master_sel(master_sel), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_err(irq_err), .irq_frame(irq_frame)
  );

  function automatic int sbit(input int i);
    int t[6] = '{12, 13, 14, 15, 5, 7};
    return t[i];
  endfunction
  function automatic int cbit(input int i);
    int t[6] = '{8, 9, 10, 11, 4, 6};
    return t[i];
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] w = '0;
    w[0] = m_en; w[1] = m_ms; w[7] = m_err[5];
    w[12:8] = m_err[4:0]; w[13] = eng_busy;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pair(input logic cur, input logic s, input logic c);
    if (s && c) return cur;
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  // one clock with given stimulus, model update, then status check
  task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] d,
                      input logic [4:0] ev, input logic bsy, input string req);
    logic sw;
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt = ev; eng_busy = bsy;
    sw = wr && a == 2'd0;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      logic hw;
      hw = (i < 5) ? (ev[i] & m_een[i]) : 1'b0;
      if (hw) m_err[i] = 1'b1;
      else m_err[i] = pair(m_err[i], sw & d[sbit(i)], sw & d[cbit(i)]);
    end
    if (sw) begin
      m_en = pair(m_en, d[1], d[0] & (!bsy | d[1]));
      m_ms = pair(m_ms, d[3], d[2]);
    end
    if (wr && a == 2'd1) m_een = d[4:0];
    if (wr && a == 2'd2) m_ie = d[3:0];
    @(negedge clk);
    bus_wr = 1'b0; evt = '0; bus_addr = 2'd0;
    #1;
    check({req, " status"}, bus_rdata, exp_status());
    check({req, " run_mode"}, run_mode, m_en);
    check({req, " master_sel"}, master_sel, m_ms);
    check({req, " R10 irq_err"}, irq_err, (|m_err) & m_ie[2]);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [15:0] w;
    seed = $urandom(7);
    m_en = 0; m_ms = 0; m_err = '0; m_een = '0; m_ie = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", bus_rdata, 16'h0);
    check("R1 run_mode", run_mode, 1'b0);
    check("R1 irq_err", irq_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 2'd1; #1; check("R1 err_en", bus_rdata, 16'h0);
    bus_addr = 2'd2; #1; check("R1 irq_en", bus_rdata, 16'h0);
    bus_addr = 2'd0;

    // R2 enable and master select
    step(1, 0, 16'h000A, 0, 0, "R2 set EN MS");
    check("R2 run_mode set", run_mode, 1'b1);
    // R6 clear ignored while busy
    step(1, 0, 16'h0001, 0, 1, "R6 clear busy");
    check("R6 held", run_mode, 1'b1);
    step(1, 0, 16'h0001, 0, 0, "R6 clear idle");
    check("R6 cleared", run_mode, 1'b0);
    step(1, 0, 16'h0004, 0, 0, "R2 clear MS");
    // R3 each error flag set singly
    for (int i = 0; i < 6; i++) step(1, 0, 16'(1 << sbit(i)), 0, 0, "R3 set");
    check("R3 all set", bus_rdata[12:7], 6'h3F);
    // R5 tie keeps
    step(1, 0, 16'hFFFF, 0, 0, "R5 tie");
    check("R5 tie held", bus_rdata[12:7], 6'h3F);
    // R4 bulk clear
    step(1, 0, 16'h0F50, 0, 0, "R4 bulk");
    check("R4 cleared", bus_rdata[12:7], 6'h00);
    // R7 event with enable off has no effect
    step(0, 0, 0, 5'h1F, 0, "R7 gated off");
    check("R7 no flags", bus_rdata[12:7], 6'h00);
    step(1, 1, 16'h001F, 0, 0, "R7 enable all");
    bus_addr = 2'd1; #1; check("R8 err_en read", bus_rdata, 16'h001F); bus_addr = 0;
    // R7 event beats clear in same cycle
    step(1, 0, 16'h0100, 5'h01, 0, "R7 event vs clear");
    check("R7 TE set", bus_rdata[8], 1'b1);
    // R10 and R9
    step(1, 2, 16'h000F, 0, 0, "R9 irq enable");
    req_rx = 1; req_tx = 1; req_frame = 1; #1;
    check("R9 irq_rx", irq_rx, 1'b1);
    check("R9 irq_frame", irq_frame, 1'b1);
    check("R10 irq_err on", irq_err, 1'b1);
    step(1, 2, 16'h0002, 0, 0, "R9 partial");
    check("R9 irq_rx off", irq_rx, 1'b0);
    check("R9 irq_tx on", irq_tx, 1'b1);
    // R11 spare address
    step(1, 3, 16'hFFFF, 0, 0, "R11 spare write");
    bus_addr = 2'd3; #1; check("R11 read zero", bus_rdata, 16'h0);
    bus_addr = 2'd2; #1; check("R11 irq_en kept", bus_rdata, 16'h0002);
    bus_addr = 2'd0;

    // random phase, R3 R6 R7 R8
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      w = 16'($urandom);
      req_rx = 1'($urandom); req_tx = 1'($urandom); req_frame = 1'($urandom);
      step(1'($urandom), a, w, 5'($urandom) & 5'($urandom), 1'($urandom), "R8 random");
      check("R9 rand irq_tx", irq_tx, req_tx & m_ie[1]);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule